// File: doc/BRIEF.md
# Automatic Recording Level Controller

This block closes the digital half of a recording level loop. It watches a stream of signed converter samples, keeps the largest magnitude seen in the current measurement window, and moves a 6-bit record gain code one step at a time. The code falls when the window peak rises above a programmed target. It rises when the window stays at or below the target long enough. The gain code drives an external programmable amplifier. A code step is 0.75 dB, and the reset code 23 is 0 dB on the extended scale, where code 0 is -17.25 dB and code 63 is +30 dB.

The falling (attack) and rising (decay) windows are each set by a 4-bit code. The window length is BASE_TICKS samples doubled once per code step, and any code of 10 or more gives the same longest window. A noise gate holds back gain increases while the signal is quiet, so the loop does not turn up background hiss during silence. When zero-cross mode is on, a changed gain is held back until the sample sign flips, or until a fixed number of samples has passed. This keeps gain steps off the peaks of the waveform.

Top module: `alc_level_ctrl`

## Requirements
- R1: After reset the gain code is GAIN_INIT (default 23, the 0 dB point), and the attack window, decay window and peak hold are empty.
- R2: The window peak is the largest sample magnitude (the most negative input reads as full scale) since the last step. While this peak exceeds cfg_target, samples count toward an attack window. On the sample that completes the window, the wanted gain falls by one and the window and peak clear.
- R3: The attack window holds BASE_TICKS << cfg_attack samples, with BASE_TICKS = 2 by default. Codes of 10 and above all give BASE_TICKS << 10 samples.
- R4: While the window peak is at or below cfg_target, samples count toward a decay window of BASE_TICKS << min(cfg_decay,10). On its last sample the wanted gain rises by one, and the window and peak clear. A sample that goes above the target restarts the decay count, and a sample at or below the target restarts the attack count.
- R5: The wanted gain changes by at most one code per accepted sample.
- R6: The gain saturates at 0 and at 63 and never wraps.
- R7: With cfg_gate_en high, a decay window that ends with a peak below cfg_gate_thr gives no increase. The window still clears.
- R8: With cfg_zc_en low, the gain code takes the new value on the clock edge that accepts the deciding sample, and it is visible one cycle later.
- R9: With cfg_zc_en high, a pending gain is applied on a sample whose sign bit (bit W-1) differs from that of the previous accepted sample. Otherwise it is applied on the ZC_TIMEOUT-th sample (default 8) counted from the sample that made it pending.
- R10: In a cycle without smp_vld, no state and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe, one accepted sample per high cycle |
| smp_data | input | W (16) | Two's complement converter sample |
| cfg_target | input | W-1 (15) | Peak magnitude target |
| cfg_attack | input | 4 | Attack window code |
| cfg_decay | input | 4 | Decay window code |
| cfg_gate_en | input | 1 | Noise gate enable |
| cfg_gate_thr | input | W-1 (15) | Noise gate magnitude threshold |
| cfg_zc_en | input | 1 | Zero-cross deferral enable |
| gain_code | output | GAIN_W (6) | Record gain code |

## Verification
Every decision is made combinationally in the cycle that carries the deciding sample and is stored on that clock edge. A new gain code is therefore due one cycle after the strobe, or later in zero-cross mode, on a sign flip or at the timeout sample. The bench drives each sample at a falling edge. It updates its reference model for that sample and compares gain_code at the next falling edge, so every check sits a whole half period away from the edge that loads the result. Idle cycles are checked the same way to confirm the code holds.

// File: rtl/alc_pkg.sv
package alc_pkg;
   // Window length in samples: base doubled per code step, saturating at cmax.
   function automatic int unsigned win_len(input logic [3:0] code,
                                           input int unsigned base,
                                           input int unsigned cmax);
      int unsigned c;
      c = (int'(code) > int'(cmax)) ? cmax : int'(code);
      return base << c;
   endfunction
endpackage

// File: rtl/alc_level_detect.sv
module alc_level_detect #(
   parameter int W          = 16,
   parameter int BASE_TICKS = 2,
   parameter int CODE_MAX   = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         smp_vld,
   input  logic [W-1:0] smp_data,
   input  logic [W-2:0] target,
   input  logic         gate_en,
   input  logic [W-2:0] gate_thr,
   input  logic [3:0]   atk_code,
   input  logic [3:0]   dec_code,
   output logic         step_up,
   output logic         step_dn
);
   import alc_pkg::*;

   localparam int MAXLEN = BASE_TICKS << CODE_MAX;
   localparam int CW     = $clog2(MAXLEN) + 1;

   logic [W-2:0] peak_q, mag, pk;
   logic [W-1:0] neg_v;
   logic [CW-1:0] atk_cnt, dec_cnt, atk_len, dec_len;
   logic over, atk_last, dec_last, gate_blk;

   // magnitude with the most negative code clamped to full scale
   always_comb begin
      neg_v = ~smp_data + 1'b1;
      if (!smp_data[W-1])   mag = smp_data[W-2:0];
      else if (neg_v[W-1])  mag = '1;
      else                  mag = neg_v[W-2:0];
   end

   assign pk       = (mag > peak_q) ? mag : peak_q;
   assign over     = pk > target;
   assign atk_len  = CW'(win_len(atk_code, BASE_TICKS, CODE_MAX));
   assign dec_len  = CW'(win_len(dec_code, BASE_TICKS, CODE_MAX));
   assign atk_last = atk_cnt >= (atk_len - 1'b1);
   assign dec_last = dec_cnt >= (dec_len - 1'b1);
   assign gate_blk = gate_en && (pk < gate_thr);
   assign step_dn  = smp_vld && over && atk_last;
   assign step_up  = smp_vld && !over && dec_last && !gate_blk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         peak_q  <= '0;
         atk_cnt <= '0;
         dec_cnt <= '0;
      end else if (smp_vld) begin
         if (over) begin
            dec_cnt <= '0;
            if (atk_last) begin
               atk_cnt <= '0;
               peak_q  <= '0;
            end else begin
               atk_cnt <= atk_cnt + 1'b1;
               peak_q  <= pk;
            end
         end else begin
            atk_cnt <= '0;
            if (dec_last) begin
               dec_cnt <= '0;
               peak_q  <= '0;
            end else begin
               dec_cnt <= dec_cnt + 1'b1;
               peak_q  <= pk;
            end
         end
      end
   end

   initial begin
      if (W < 4 || BASE_TICKS < 1 || CODE_MAX < 0 || CODE_MAX > 15)
         $error("alc_level_detect: bad parameters");
   end

   p_atk_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step_dn |=> (atk_cnt == '0 && peak_q == '0));
   p_dec_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !over && dec_last) |=> (dec_cnt == '0 && peak_q == '0));
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> ($stable(peak_q) && $stable(atk_cnt) && $stable(dec_cnt)));
endmodule

// File: rtl/alc_gain_step.sv
module alc_gain_step #(
   parameter int GAIN_W     = 6,
   parameter int GAIN_INIT  = 23,
   parameter int ZC_TIMEOUT = 8,
   parameter bit ZC_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic              smp_sign,
   input  logic              step_up,
   input  logic              step_dn,
   input  logic              zc_en,
   output logic [GAIN_W-1:0] gain
);
   localparam logic [GAIN_W-1:0] GMAX  = '1;
   localparam logic [GAIN_W-1:0] GINIT = GAIN_W'(GAIN_INIT);
   localparam int TW = $clog2(ZC_TIMEOUT) + 1;
   localparam logic [TW-1:0] TLAST = TW'(ZC_TIMEOUT - 1);

   logic [GAIN_W-1:0] want_q, want_d;

   always_comb begin
      want_d = want_q;
      if (step_dn && want_q != '0)        want_d = want_q - 1'b1;
      else if (step_up && want_q != GMAX) want_d = want_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       want_q <= GINIT;
      else if (smp_vld) want_q <= want_d;
   end

   generate
      if (ZC_SUPPORT) begin : g_zc
         logic [GAIN_W-1:0] gain_q;
         logic [TW-1:0]     to_cnt;
         logic              sign_q, apply;

         assign apply = !zc_en || (smp_sign != sign_q) || (to_cnt >= TLAST);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               gain_q <= GINIT;
               to_cnt <= '0;
               sign_q <= 1'b0;
            end else if (smp_vld) begin
               sign_q <= smp_sign;
               if (apply) begin
                  gain_q <= want_d;
                  to_cnt <= '0;
               end else if (gain_q != want_d) begin
                  to_cnt <= to_cnt + 1'b1;
               end else begin
                  to_cnt <= '0;
               end
            end
         end
         assign gain = gain_q;

         p_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_vld && !zc_en) |=> (gain_q == want_q));
         p_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_vld && to_cnt >= TLAST) |=> (gain_q == want_q));
      end else begin : g_direct
         logic zc_unused;
         assign zc_unused = zc_en ^ smp_sign;
         assign gain = want_q;
      end
   endgenerate

   initial begin
      if (GAIN_W < 2 || GAIN_INIT < 0 || GAIN_INIT >= (1 << GAIN_W) || ZC_TIMEOUT < 1)
         $error("alc_gain_step: bad parameters");
   end

   p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (want_q == $past(want_q)) || (want_q == $past(want_q) + 1'b1) ||
      (want_q == $past(want_q) - 1'b1));
   p_no_wrap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (want_q == GMAX) |=> (want_q != '0));
   p_no_wrap_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (want_q == '0) |=> (want_q != GMAX));
endmodule

// File: rtl/alc_level_ctrl.sv
module alc_level_ctrl #(
   parameter int W          = 16,
   parameter int GAIN_W     = 6,
   parameter int GAIN_INIT  = 23,
   parameter int BASE_TICKS = 2,
   parameter int CODE_MAX   = 10,
   parameter int ZC_TIMEOUT = 8,
   parameter bit ZC_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [W-1:0]      smp_data,
   input  logic [W-2:0]      cfg_target,
   input  logic [3:0]        cfg_attack,
   input  logic [3:0]        cfg_decay,
   input  logic              cfg_gate_en,
   input  logic [W-2:0]      cfg_gate_thr,
   input  logic              cfg_zc_en,
   output logic [GAIN_W-1:0] gain_code
);
   logic up, dn;

   alc_level_detect #(.W(W), .BASE_TICKS(BASE_TICKS), .CODE_MAX(CODE_MAX)) u_det (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .target(cfg_target), .gate_en(cfg_gate_en), .gate_thr(cfg_gate_thr),
      .atk_code(cfg_attack), .dec_code(cfg_decay), .step_up(up), .step_dn(dn));

   alc_gain_step #(.GAIN_W(GAIN_W), .GAIN_INIT(GAIN_INIT), .ZC_TIMEOUT(ZC_TIMEOUT),
                   .ZC_SUPPORT(ZC_SUPPORT)) u_gain (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_sign(smp_data[W-1]),
      .step_up(up), .step_dn(dn), .zc_en(cfg_zc_en), .gain(gain_code));

   p_gain_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(gain_code));
   p_one_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(up && dn));
endmodule

// File: tb/sim_alc_level_ctrl.sv
module sim_alc_level_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_vld = 1'b0;
   logic [15:0] smp_data = '0;
   logic [14:0] cfg_target = 15'd1000;
   logic [3:0]  cfg_attack = 4'd2;
   logic [3:0]  cfg_decay = 4'd0;
   logic        cfg_gate_en = 1'b0;
   logic [14:0] cfg_gate_thr = '0;
   logic        cfg_zc_en = 1'b0;
   logic [5:0]  gain_code;

   int n_chk = 0, n_bad = 0;
   int m_gain, m_want, m_atk, m_dec, m_peak, m_to;
   bit m_sign;

   always #4 clk = ~clk;

   alc_level_ctrl u0 (.clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .cfg_target(cfg_target), .cfg_attack(cfg_attack), .cfg_decay(cfg_decay),
      .cfg_gate_en(cfg_gate_en), .cfg_gate_thr(cfg_gate_thr), .cfg_zc_en(cfg_zc_en),
      .gain_code(gain_code));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int wlen(input logic [3:0] c);
      return 2 << ((c > 4'd10) ? 10 : int'(c));
   endfunction

   task automatic model_sample(input logic [15:0] d);
      int sv, mag, pk;
      bit over, up, dn, apply;
      int wd;
      sv = $signed(d);
      mag = (sv < 0) ? -sv : sv;
      if (mag > 32767) mag = 32767;
      pk = (mag > m_peak) ? mag : m_peak;
      over = pk > int'(cfg_target);
      up = 0; dn = 0;
      if (over) begin
         m_dec = 0;
         if (m_atk >= wlen(cfg_attack) - 1) begin dn = 1; m_atk = 0; m_peak = 0; end
         else begin m_atk++; m_peak = pk; end
      end else begin
         m_atk = 0;
         if (m_dec >= wlen(cfg_decay) - 1) begin
            up = !(cfg_gate_en && pk < int'(cfg_gate_thr));
            m_dec = 0; m_peak = 0;
         end else begin m_dec++; m_peak = pk; end
      end
      wd = m_want;
      if (dn && wd > 0) wd--;
      else if (up && wd < 63) wd++;
      apply = !cfg_zc_en || (d[15] != m_sign) || (m_to >= 7);
      if (apply) begin m_gain = wd; m_to = 0; end
      else if (m_gain != wd) m_to++;
      else m_to = 0;
      m_sign = d[15];
      m_want = wd;
   endtask

   // called at a falling edge; returns at the next falling edge after compare
   task automatic send(input logic [15:0] d);
      smp_vld = 1'b1;
      smp_data = d;
      model_sample(d);
      @(posedge clk);
      @(negedge clk);
      smp_vld = 1'b0;
      check(gain_code == 6'(m_gain), "R5 model", int'(gain_code), m_gain);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         smp_data = 16'h8000;
         @(posedge clk);
         @(negedge clk);
         check(gain_code == 6'(m_gain), "R10 idle hold", int'(gain_code), m_gain);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      smp_vld = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_gain = 23; m_want = 23; m_atk = 0; m_dec = 0; m_peak = 0; m_to = 0; m_sign = 0;
   endtask

   initial begin
      #(8 * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      @(negedge clk);
      do_reset();
      check(gain_code == 6'd23, "R1 reset gain", int'(gain_code), 23);

      // R2/R3/R8: attack code 0 -> 2-sample window, immediate apply
      cfg_attack = 4'd0; cfg_target = 15'd1000;
      send(16'd5000);
      check(gain_code == 6'd23, "R3 one sample short", int'(gain_code), 23);
      send(16'hEC78); // -5000
      check(gain_code == 6'd22, "R2 attack step", int'(gain_code), 22);
      check(gain_code == 6'd22, "R8 immediate", int'(gain_code), 22);

      // R3: saturated attack code gives 2048 samples
      do_reset();
      cfg_attack = 4'd13;
      for (int i = 0; i < 2047; i++) send(16'd3000);
      check(gain_code == 6'd23, "R3 saturated window short", int'(gain_code), 23);
      send(16'd3000);
      check(gain_code == 6'd22, "R3 saturated window", int'(gain_code), 22);

      // R4/R6: decay up to top, stays
      do_reset();
      cfg_decay = 4'd0; cfg_attack = 4'd0;
      for (int i = 0; i < 100; i++) send(16'd10);
      check(gain_code == 6'd63, "R6 top saturate", int'(gain_code), 63);
      check(gain_code == 6'd63, "R4 decay rises", int'(gain_code), 63);
      for (int i = 0; i < 150; i++) send(16'd8000);
      check(gain_code == 6'd0, "R6 bottom saturate", int'(gain_code), 0);

      // R4: over-target sample restarts decay count
      do_reset();
      cfg_decay = 4'd1; cfg_attack = 4'd3; // 4 and 16 samples
      send(16'd10); send(16'd10); send(16'd10); send(16'd2000);
      send(16'd10); send(16'd10); send(16'd10);
      check(gain_code == 6'd23, "R4 restart", int'(gain_code), 23);

      // R7: gate blocks increases
      do_reset();
      cfg_decay = 4'd0; cfg_gate_en = 1'b1; cfg_gate_thr = 15'd200;
      for (int i = 0; i < 20; i++) send(16'd50);
      check(gain_code == 6'd23, "R7 gate closed", int'(gain_code), 23);
      send(16'd300); send(16'd300);
      check(gain_code == 6'd24, "R7 gate open", int'(gain_code), 24);
      cfg_gate_en = 1'b0;

      // R10: idle cycles change nothing
      idle(5);
      check(gain_code == 6'd24, "R10 idle", int'(gain_code), 24);

      // R9: zero-cross deferral and timeout
      do_reset();
      cfg_zc_en = 1'b1; cfg_attack = 4'd0; cfg_target = 15'd1000;
      send(16'd5000); send(16'd5000); send(16'd5000);
      check(gain_code == 6'd23, "R9 deferred", int'(gain_code), 23);
      send(16'hEC78);
      check(gain_code == 6'd21, "R9 sign flip apply", int'(gain_code), 21);
      for (int i = 0; i < 8; i++) send(16'd5000);
      check(gain_code == 6'd21, "R9 before timeout", int'(gain_code), 21);
      send(16'd5000);
      check(gain_code == 6'd17, "R9 timeout apply", int'(gain_code), 17);

      // random phase
      do_reset();
      for (int b = 0; b < 24; b++) begin
         int amp;
         cfg_attack = 4'($urandom % 12);
         cfg_decay = 4'($urandom % 8);
         cfg_target = 15'($urandom % 20000);
         cfg_gate_en = 1'($urandom % 2);
         cfg_gate_thr = 15'($urandom % 4000);
         cfg_zc_en = 1'($urandom % 2);
         amp = (b % 3 == 0) ? 500 : 32768;
         for (int i = 0; i < 200; i++) begin
            int v;
            v = int'($urandom % (2 * amp)) - amp;
            if ($urandom % 8 == 0) idle(1);
            send(16'(v));
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule